// File: doc/BRIEF.md
# Two-Bank Interleaved Read Sequencer

This block sits between a host read port and two identical memory banks. Word addresses with a clear low bit live in the even bank and those with the low bit set live in the odd bank. Each bank is started with a one-cycle strobe and a bank-local address (the word address shifted right by one). Some fixed number of cycles later the bank answers with a one-cycle data-valid pulse. A bank then needs a full bank cycle, which is its access latency plus its precharge, before it can take another start.

On a sequential stream the accesses alternate between the banks. The sequencer starts the next bank while the current one is still in its latency and precharge. After the first word the host therefore receives one word every transfer slot (`XFER` cycles) and not one word every bank cycle (`BCYC` cycles). When two requests in a row fall in the same bank there is nothing to overlap. The sequencer holds the second request until that bank's cycle has elapsed. Returned words are held in a one-word register per bank and handed to the host in acceptance order, marked by a single valid strobe.

The host offers a request with `req_valid` and `req_addr`. The request is taken in any cycle where `req_ready` is high. There is no backpressure on the return side.

Top module: `ilv_seq`

## Requirements
- R1: A request whose word address has bit 0 equal to 0 starts only the even bank, and one with bit 0 equal to 1 starts only the odd bank. The bank address is the word address without bit 0. The start strobe is asserted in the same cycle the request is accepted.
- R2: In the first cycle after reset is released, `rd_valid` is low and `req_ready` is high.
- R3: Two starts to either bank are never closer than `XFER` cycles apart.
- R4: Two starts to the same bank are never closer than `BCYC` cycles apart.
- R5: A stream of consecutive ascending addresses, offered back to back, is accepted exactly once every `XFER` cycles.
- R6: A stream whose addresses all fall in one bank is accepted exactly once every `BCYC` cycles.
- R7: A bank's data-valid pulse in cycle t produces `rd_valid` in cycle t+1 when that word is the oldest one outstanding.
- R8: Words reach the host in the order their requests were accepted. Each word appears for exactly one cycle on `rd_valid`, and `rd_data` carries the word its bank returned.
- R9: A bank is not started again while its previous word has not yet been handed to the host.
- R10: In a cycle with `req_valid` low, no bank is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read |
| req_addr | input | AW | Word address of the read |
| req_ready | output | 1 | Read is accepted this cycle if offered |
| rd_valid | output | 1 | Returned word is valid this cycle |
| rd_data | output | DW | Returned word |
| ev_start | output | 1 | Start strobe to the even bank |
| ev_addr | output | AW-1 | Bank address for the even bank |
| ev_valid | input | 1 | Even bank data-valid pulse |
| ev_data | input | DW | Even bank data |
| od_start | output | 1 | Start strobe to the odd bank |
| od_addr | output | AW-1 | Bank address for the odd bank |
| od_valid | input | 1 | Odd bank data-valid pulse |
| od_data | input | DW | Odd bank data |

## Verification
The bench drives several streams: an ascending stream, which exposes a sequencer that fails to overlap (acceptance every `BCYC` cycles where every `XFER` was due); a single-bank stream, which catches one that overlaps a bank with itself (starts closer than the bank cycle, or a held word overwritten); and a shuffled mix, where a wrong oldest-word pointer would show up as swapped or repeated return data. Idle cycles inside a stream catch a start issued without a valid request or a spacing counter that does not recover, and the cycle right after reset checks that the port does not start out stalled or report stale data.

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int XFER = 4,
  parameter int BCYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ev_start,
  output logic [AW-2:0] ev_addr,
  input  logic          ev_valid,
  input  logic [DW-1:0] ev_data,
  output logic          od_start,
  output logic [AW-2:0] od_addr,
  input  logic          od_valid,
  input  logic [DW-1:0] od_data
);
  localparam int CW = $clog2(BCYC + 1);

  logic [1:0]    busy, hold_v, bank_v, free, pop, push;
  logic [DW-1:0] hold_d [2];
  logic [DW-1:0] bank_d [2];
  logic [CW-1:0] bcnt [2];
  logic [CW-1:0] gap;
  logic          head, sel, go;

  assign sel       = req_addr[0];
  assign bank_v    = {od_valid, ev_valid};
  assign bank_d[0] = ev_data;
  assign bank_d[1] = od_data;
  assign free[0]   = !busy[0] && (bcnt[0] == '0);
  assign free[1]   = !busy[1] && (bcnt[1] == '0);
  assign req_ready = free[sel] && (gap == '0);
  assign go        = req_valid && req_ready;
  assign push      = {go && sel, go && !sel};
  assign ev_start  = push[0];
  assign od_start  = push[1];
  assign ev_addr   = req_addr[AW-1:1];
  assign od_addr   = req_addr[AW-1:1];
  assign rd_valid  = hold_v[head];
  assign rd_data   = hold_d[head];
  assign pop       = rd_valid ? (head ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      busy   <= '0;
      hold_v <= '0;
      head   <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        bcnt[b]   <= '0;
        hold_d[b] <= '0;
      end
    end else begin
      if (go)             gap <= CW'(XFER - 1);
      else if (gap != '0) gap <= gap - 1'b1;
      for (int b = 0; b < 2; b++) begin
        if (push[b])            bcnt[b] <= CW'(BCYC - 1);
        else if (bcnt[b] != '0) bcnt[b] <= bcnt[b] - 1'b1;
        busy[b] <= push[b] || (busy[b] && !pop[b]);
        if (bank_v[b] && busy[b] && !hold_v[b]) begin
          hold_v[b] <= 1'b1;
          hold_d[b] <= bank_d[b];
        end else if (pop[b]) begin
          hold_v[b] <= 1'b0;
        end
      end
      if (go && ((busy & ~pop) == 2'b00)) head <= sel;
      else if (pop != 2'b00)              head <= !head;
    end
  end

  logic [CW-1:0] since_any;
  logic [CW-1:0] since_b [2];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any  <= CW'(BCYC);
      since_b[0] <= CW'(BCYC);
      since_b[1] <= CW'(BCYC);
    end else begin
      if (ev_start || od_start)       since_any <= CW'(1);
      else if (since_any < CW'(BCYC)) since_any <= since_any + 1'b1;
      for (int b = 0; b < 2; b++) begin
        if (push[b])                   since_b[b] <= CW'(1);
        else if (since_b[b] < CW'(BCYC)) since_b[b] <= since_b[b] + 1'b1;
      end
    end
  end

  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && od_start));
  p_reset_idle_r2: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);
  p_slot_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || od_start) |-> since_any >= CW'(XFER));
  p_even_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> since_b[0] >= CW'(BCYC));
  p_odd_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    od_start |-> since_b[1] >= CW'(BCYC));
  p_held_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start |-> !hold_v[0]) and (od_start |-> !hold_v[1]));
  p_word_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !(hold_v[$past(head)]));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(ev_start || od_start));
endmodule

// File: tb/test_ilv_seq.sv
module test_ilv_seq;
  localparam int AW = 8, DW = 16, XFER = 4, BCYC = 8, LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ev_valid = 1'b0, od_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] ev_data = '0, od_data = '0, rd_data;
  logic req_ready, rd_valid, ev_start, od_start;
  logic [AW-2:0] ev_addr, od_addr;

  always #2 clk = !clk;

  ilv_seq #(.AW(AW), .DW(DW), .XFER(XFER), .BCYC(BCYC)) i_ilv_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .ev_start(ev_start), .ev_addr(ev_addr), .ev_valid(ev_valid), .ev_data(ev_data),
    .od_start(od_start), .od_addr(od_addr), .od_valid(od_valid), .od_data(od_data));

  int checks = 0, fails = 0, cyc = 0;
  int last_b [2] = '{-1000, -1000};
  int busy_until [2] = '{0, 0};
  int last_any = -1000;
  int due [2] = '{-1, -1};
  int dword [2];
  int exp_due[$], exp_word[$], stim[$], acc[$];

  function automatic int word_of(int a);
    return (a * 37 + 16'h1234) & 16'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    int a, b, exp_rdy, exp_rv;
    @(negedge clk);
    a = (stim.size() > 0) ? stim[0] : -1;
    req_valid = (a >= 0);
    req_addr  = (a >= 0) ? AW'(a) : AW'(cyc);
    ev_valid = (due[0] == cyc);
    od_valid = (due[1] == cyc);
    ev_data  = DW'(dword[0]);
    od_data  = DW'(dword[1]);
    #1;
    b = req_addr[0];
    exp_rdy = (cyc >= last_b[b] + BCYC) && (cyc >= busy_until[b]) && (cyc >= last_any + XFER);
    chk(req_ready == exp_rdy, "R3/R4 req_ready", req_ready, exp_rdy);
    exp_rv = (exp_due.size() > 0 && exp_due[0] == cyc);
    chk(rd_valid == exp_rv, "R7 rd_valid timing", rd_valid, exp_rv);
    if (exp_rv) begin
      chk(rd_data == DW'(exp_word[0]), "R8 rd_data order", rd_data, exp_word[0]);
      void'(exp_due.pop_front());
      void'(exp_word.pop_front());
    end
    if (a >= 0 && exp_rdy) begin
      chk(ev_start == !b && od_start == b, "R1 bank select", {ev_start, od_start}, {!b, b});
      chk((b ? od_addr : ev_addr) == (AW-1)'(a >> 1), "R1 bank address",
          b ? od_addr : ev_addr, a >> 1);
      last_b[b] = cyc; last_any = cyc; busy_until[b] = cyc + LAT + 2;
      due[b] = cyc + LAT; dword[b] = word_of(a);
      exp_due.push_back(cyc + LAT + 1); exp_word.push_back(word_of(a));
      acc.push_back(cyc);
    end else begin
      chk(!ev_start && !od_start, "R10 no start", {ev_start, od_start}, 0);
    end
    if (a < 0 || exp_rdy) if (stim.size() > 0) void'(stim.pop_front());
    cyc++;
  endtask

  task automatic drain();
    int n = 0;
    while ((stim.size() > 0 || exp_due.size() > 0) && n < 2000) begin
      step(); n++;
    end
    chk(n < 2000, "drain", n, 0);
  endtask

  task automatic spacing(input int gap, input string req);
    for (int i = 1; i < acc.size(); i++)
      chk(acc[i] - acc[i-1] == gap, req, acc[i] - acc[i-1], gap);
    acc.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R2 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1 && rd_valid == 1'b0, "R2 after reset", {req_ready, rd_valid}, 2'b10);
    @(posedge clk);
    cyc = 0;
    // R5 ascending stream
    for (int i = 0; i < 12; i++) stim.push_back(i);
    drain();
    spacing(XFER, "R5 sequential spacing");
    // R6 single-bank stream
    for (int i = 0; i < 6; i++) stim.push_back(2 * i + 20);
    drain();
    spacing(BCYC, "R6 same-bank spacing");
    for (int i = 0; i < 5; i++) stim.push_back(2 * i + 41);
    drain();
    spacing(BCYC, "R6 odd-bank spacing");
    // R8/R9/R10 shuffled mix with idle cycles
    foreach (stim[i]) ;
    stim.push_back(7); stim.push_back(9); stim.push_back(-1); stim.push_back(10);
    stim.push_back(3); stim.push_back(-1); stim.push_back(-1); stim.push_back(4);
    stim.push_back(4); stim.push_back(255); stim.push_back(128); stim.push_back(-1);
    stim.push_back(129); stim.push_back(130); stim.push_back(60); stim.push_back(61);
    drain();
    acc.delete();
    repeat (10) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule